// File: doc/BRIEF.md
# Reference-Gated Frequency Meter

This block estimates the rate of an oscillator by comparing it with a trusted reference clock. The reference domain opens a gate for a programmed number of reference cycles. The selected oscillator, after an optional prescaler, counts its own edges while that gate is open. The result is a 16-bit count, and the oscillator frequency follows from the count, the window length and the reference rate. With a 26 MHz reference and a load value of 0x1FF, the window is 512 reference cycles, so the frequency in MHz is count × 26 / 512. The count to aim for during calibration is therefore target_MHz × 512 / 26.

Software drives the block from the register clock domain. It sets the enable level first, then pulses the run request. The run indication stays high while a measurement is in flight and drops by itself once the result is stored. Software polls that one bit and reads the count once the bit has dropped. Dropping the enable turns the meter off for further requests.

The start request, the gate and the completion flag cross three clock domains through multi-flop synchronisers and a four-phase handshake. The count is only sampled once the measured domain has acknowledged that the gate is closed. Source, window length and prescaler settings are latched when a run starts.

Top module: `freq_meter`

## Requirements
- R1: After reset, `run_busy` is 0 and `count_out` is 0.
- R2: A `run_set` pulse sampled while `meter_en` is 1 and the meter is idle makes `run_busy` read 1 after the next `clk` edge. Holding `meter_en` at 1 without a pulse starts nothing.
- R3: The measurement window lasts `win_load`+1 reference cycles. With a prescaler value of 0, `count_out` equals the measured frequency times the window length, within ±2 counts.
- R4: `src_sel` = i routes `osc_clk[i]` into the meter. Value 0 selects bit 0 and value 1 selects bit 1.
- R5: A `prediv` value of d increments the count once for every d+1 measured edges. A value of 0 divides by 1.
- R6: `run_busy` drops by itself once the result is stored. `count_out` changes only while `run_busy` is 1, and it holds its value while idle.
- R7: If the measured clock is too fast for the window, the count stops at 0xFFFF and does not wrap.
- R8: Each run clears the counter at its start, so a result reflects only that run's window.
- R9: A `run_set` pulse while `meter_en` is 0 is ignored: `run_busy` stays 0 and `count_out` is unchanged.
- R10: A `run_set` pulse while busy is ignored. Changes to `src_sel`, `win_load` or `prediv` during a run do not affect that run's result.
- R11: A `win_load` of 0 gives a window of exactly one reference cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset for all domains |
| ref_clk | input | 1 | Known reference clock that times the window |
| osc_clk | input | N_SRC | Oscillator clocks that can be measured |
| meter_en | input | 1 | Meter enable level |
| run_set | input | 1 | One-cycle request to start a measurement |
| src_sel | input | SEL_W | Index of the oscillator to measure |
| win_load | input | WIN_W | Window length minus one, in reference cycles |
| prediv | input | DIV_W | Prescaler value; counts every prediv+1 edges |
| run_busy | output | 1 | Run indication; clears itself when the result is stored |
| count_out | output | CNT_W | Last measured count |

## Verification
A broken window counter or gate crossing shows up as a count that is wrong in proportion to the window error. A broken handshake state leaves `run_busy` stuck high, and the run never completes within the expected window plus a few synchroniser cycles. A counter that is not cleared or that wraps shows up at once in the next small or saturating measurement. If configuration is not latched, the result of a run reconfigured mid-way moves away from the count of the original setting.

// File: rtl/fm_pkg.sv
`timescale 1ns/1ps
package fm_pkg;
   // Register-domain sequencing of one measurement
   typedef enum logic [1:0] {
      C_IDLE  = 2'd0,
      C_RUN   = 2'd1,
      C_DRAIN = 2'd2
   } ctrl_st_e;

   // Reference-domain window sequencing
   typedef enum logic [1:0] {
      W_IDLE  = 2'd0,
      W_GATE  = 2'd1,
      W_FLUSH = 2'd2,
      W_DONE  = 2'd3
   } win_st_e;

   function automatic int sel_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/fm_sync.sv
`timescale 1ns/1ps
module fm_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] sr;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) sr[0] <= 1'b0;
               else        sr[0] <= d;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) sr[i] <= 1'b0;
               else        sr[i] <= sr[i-1];
         end
      end
   endgenerate

   assign q = sr[STAGES-1];
endmodule

// File: rtl/fm_ctrl.sv
`timescale 1ns/1ps
module fm_ctrl
   import fm_pkg::*;
#(
   parameter int SEL_W = 1,
   parameter int WIN_W = 16,
   parameter int CNT_W = 16,
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             meter_en,
   input  logic             run_set,
   input  logic [SEL_W-1:0] src_sel,
   input  logic [WIN_W-1:0] win_load,
   input  logic [DIV_W-1:0] prediv,
   input  logic             done_s,
   input  logic [CNT_W-1:0] meas_cnt,
   output logic             req,
   output logic             run_busy,
   output logic [CNT_W-1:0] count_out,
   output logic [SEL_W-1:0] src_q,
   output logic [WIN_W-1:0] win_q,
   output logic [DIV_W-1:0] div_q
);
   ctrl_st_e st;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= C_IDLE;
         req       <= 1'b0;
         src_q     <= '0;
         win_q     <= '0;
         div_q     <= '0;
         count_out <= '0;
      end else begin
         case (st)
            C_IDLE: if (run_set && meter_en) begin
               st    <= C_RUN;
               req   <= 1'b1;
               src_q <= src_sel;
               win_q <= win_load;
               div_q <= prediv;
            end
            C_RUN: if (done_s) begin
               // measured domain has stopped counting: the bus is stable
               count_out <= meas_cnt;
               req       <= 1'b0;
               st        <= C_DRAIN;
            end
            C_DRAIN: if (!done_s) st <= C_IDLE;
            default: begin
               st  <= C_IDLE;
               req <= 1'b0;
            end
         endcase
      end
   end

   assign run_busy = (st != C_IDLE);
endmodule

// File: rtl/fm_ref_window.sv
`timescale 1ns/1ps
module fm_ref_window
   import fm_pkg::*;
#(
   parameter int WIN_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             ref_clk,
   input  logic             rst_n,
   input  logic             req,
   input  logic [WIN_W-1:0] win_q,
   input  logic             ack,
   output logic             gate,
   output logic             done
);
   logic             req_s;
   logic             ack_s;
   logic             seen;
   logic [WIN_W-1:0] wcnt;
   win_st_e          st;

   fm_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
      .clk(ref_clk), .rst_n(rst_n), .d(req), .q(req_s));
   fm_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
      .clk(ref_clk), .rst_n(rst_n), .d(ack), .q(ack_s));

   always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= W_IDLE;
         wcnt <= '0;
         gate <= 1'b0;
         done <= 1'b0;
         seen <= 1'b0;
      end else begin
         case (st)
            W_IDLE: if (req_s) begin
               st   <= W_GATE;
               gate <= 1'b1;
               wcnt <= win_q;
               seen <= 1'b0;
            end
            W_GATE: begin
               if (ack_s) seen <= 1'b1;
               if (wcnt == '0) begin
                  gate <= 1'b0;
                  st   <= W_FLUSH;
               end else begin
                  wcnt <= wcnt - 1'b1;
               end
            end
            W_FLUSH: begin
               if (ack_s) seen <= 1'b1;
               // measured side saw the gate and has since seen it close
               if (seen && !ack_s) begin
                  done <= 1'b1;
                  st   <= W_DONE;
               end
            end
            W_DONE: if (!req_s) begin
               done <= 1'b0;
               st   <= W_IDLE;
            end
            default: st <= W_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/fm_meas_count.sv
`timescale 1ns/1ps
module fm_meas_count #(
   parameter int CNT_W       = 16,
   parameter int DIV_W       = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit SATURATE    = 1'b1
) (
   input  logic             meas_clk,
   input  logic             rst_n,
   input  logic             gate,
   input  logic [DIV_W-1:0] div_q,
   output logic             ack,
   output logic [CNT_W-1:0] cnt
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic             gate_s;
   logic             gate_d;
   logic [DIV_W-1:0] pre;
   logic [CNT_W-1:0] cnt_nxt;

   fm_sync #(.STAGES(SYNC_STAGES)) u_gate_sync (
      .clk(meas_clk), .rst_n(rst_n), .d(gate), .q(gate_s));

   assign ack = gate_s;

   generate
      if (SATURATE) begin : g_sat
         assign cnt_nxt = (cnt == CNT_MAX) ? cnt : cnt + 1'b1;
      end else begin : g_wrap
         assign cnt_nxt = cnt + 1'b1;
      end
   endgenerate

   always_ff @(posedge meas_clk or negedge rst_n) begin
      if (!rst_n) begin
         gate_d <= 1'b0;
         pre    <= '0;
         cnt    <= '0;
      end else begin
         gate_d <= gate_s;
         if (gate_s && !gate_d) begin
            pre <= '0;
            cnt <= '0;
         end else if (gate_s) begin
            if (pre == div_q) begin
               pre <= '0;
               cnt <= cnt_nxt;
            end else begin
               pre <= pre + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/freq_meter.sv
`timescale 1ns/1ps
module freq_meter
   import fm_pkg::*;
#(
   parameter int N_SRC       = 2,
   parameter int WIN_W       = 16,
   parameter int CNT_W       = 16,
   parameter int DIV_W       = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit SATURATE    = 1'b1,
   localparam int SEL_W      = sel_width(N_SRC)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_clk,
   input  logic [N_SRC-1:0] osc_clk,
   input  logic             meter_en,
   input  logic             run_set,
   input  logic [SEL_W-1:0] src_sel,
   input  logic [WIN_W-1:0] win_load,
   input  logic [DIV_W-1:0] prediv,
   output logic             run_busy,
   output logic [CNT_W-1:0] count_out
);
   initial begin
      if (N_SRC < 2)       $fatal(1, "freq_meter: N_SRC must be at least 2");
      if (SYNC_STAGES < 2) $fatal(1, "freq_meter: SYNC_STAGES must be at least 2");
      if (CNT_W < 2)       $fatal(1, "freq_meter: CNT_W too small");
      if (WIN_W < 1)       $fatal(1, "freq_meter: WIN_W too small");
      if (DIV_W < 1)       $fatal(1, "freq_meter: DIV_W too small");
   end

   logic             req;
   logic             gate;
   logic             done;
   logic             done_s;
   logic             ack;
   logic             meas_clk;
   logic [CNT_W-1:0] meas_cnt;
   logic [SEL_W-1:0] cfg_src;
   logic [WIN_W-1:0] cfg_win;
   logic [DIV_W-1:0] cfg_div;

   // Source mux; the select only changes on a start, while the gate is closed
   always_comb begin
      meas_clk = osc_clk[0];
      for (int i = 1; i < N_SRC; i++)
         if (int'(cfg_src) == i) meas_clk = osc_clk[i];
   end

   fm_ctrl #(.SEL_W(SEL_W), .WIN_W(WIN_W), .CNT_W(CNT_W), .DIV_W(DIV_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .meter_en(meter_en), .run_set(run_set),
      .src_sel(src_sel), .win_load(win_load), .prediv(prediv),
      .done_s(done_s), .meas_cnt(meas_cnt), .req(req), .run_busy(run_busy),
      .count_out(count_out), .src_q(cfg_src), .win_q(cfg_win), .div_q(cfg_div));

   fm_sync #(.STAGES(SYNC_STAGES)) u_done_sync (
      .clk(clk), .rst_n(rst_n), .d(done), .q(done_s));

   fm_ref_window #(.WIN_W(WIN_W), .SYNC_STAGES(SYNC_STAGES)) u_win (
      .ref_clk(ref_clk), .rst_n(rst_n), .req(req), .win_q(cfg_win),
      .ack(ack), .gate(gate), .done(done));

   fm_meas_count #(.CNT_W(CNT_W), .DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES),
                   .SATURATE(SATURATE)) u_meas (
      .meas_clk(meas_clk), .rst_n(rst_n), .gate(gate), .div_q(cfg_div),
      .ack(ack), .cnt(meas_cnt));
endmodule

// File: rtl/freq_meter_chk.sv
`timescale 1ns/1ps
module freq_meter_chk #(
   parameter int SEL_W    = 1,
   parameter int WIN_W    = 16,
   parameter int CNT_W    = 16,
   parameter int DIV_W    = 8,
   parameter bit SATURATE = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             meter_en,
   input logic             run_set,
   input logic             run_busy,
   input logic [CNT_W-1:0] count_out,
   input logic             meas_clk,
   input logic [CNT_W-1:0] meas_cnt,
   input logic [SEL_W-1:0] cfg_src,
   input logic [WIN_W-1:0] cfg_win,
   input logic [DIV_W-1:0] cfg_div
);
   AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run_busy) |-> $past(run_set && meter_en)); // R2

   AST_RESULT_ONLY_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(count_out) |-> (run_busy && $past(run_busy))); // R6

   AST_DISABLED_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!meter_en && !run_busy) |=> !run_busy); // R9

   AST_CFG_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
      (run_busy && $past(run_busy)) |->
         ($stable(cfg_src) && $stable(cfg_win) && $stable(cfg_div))); // R10

   generate
      if (SATURATE) begin : g_sat_chk
         AST_NO_WRAP: assert property (@(posedge meas_clk) disable iff (!rst_n)
            (meas_cnt < $past(meas_cnt)) |-> (meas_cnt == '0)); // R7
      end
   endgenerate
endmodule

bind freq_meter freq_meter_chk #(
   .SEL_W(SEL_W), .WIN_W(WIN_W), .CNT_W(CNT_W), .DIV_W(DIV_W), .SATURATE(SATURATE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .meter_en(meter_en), .run_set(run_set),
   .run_busy(run_busy), .count_out(count_out), .meas_clk(meas_clk),
   .meas_cnt(meas_cnt), .cfg_src(cfg_src), .cfg_win(cfg_win), .cfg_div(cfg_div));

// File: tb/freq_meter_test.sv
`timescale 1ns/1ps
module freq_meter_test;
   logic        clk = 1'b0;
   logic        ref_clk = 1'b0;
   logic        osc0 = 1'b0;
   logic        osc1 = 1'b0;
   logic        rst_n = 1'b0;
   logic        meter_en = 1'b0;
   logic        run_set = 1'b0;
   logic [0:0]  src_sel = '0;
   logic [15:0] win_load = '0;
   logic [7:0]  prediv = '0;
   logic        run_busy;
   logic [15:0] count_out;

   realtime h0 = 5.0;   // osc0 half period
   realtime h1 = 8.0;   // osc1 half period
   localparam real REF_T = 40.0;

   int n_chk = 0;
   int n_fail = 0;

   always #4 clk = ~clk;
   always #20 ref_clk = ~ref_clk;
   always #(h0) osc0 = ~osc0;
   always #(h1) osc1 = ~osc1;

   freq_meter uut (
      .clk(clk), .rst_n(rst_n), .ref_clk(ref_clk), .osc_clk({osc1, osc0}),
      .meter_en(meter_en), .run_set(run_set), .src_sel(src_sel),
      .win_load(win_load), .prediv(prediv), .run_busy(run_busy),
      .count_out(count_out));

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic near(input int act, input int exp, input int tol, input string tag);
      chk((act >= exp - tol) && (act <= exp + tol), tag, act, exp);
   endtask

   function automatic int expect_cnt(input int L, input real tosc, input int div);
      return $rtoi(((L + 1) * REF_T) / (tosc * (div + 1)));
   endfunction

   task automatic pulse_run();
      @(negedge clk); run_set = 1'b1;
      @(negedge clk); run_set = 1'b0;
   endtask

   task automatic wait_idle(output bit fin);
      fin = 1'b0;
      for (int i = 0; i < 60000; i++) begin
         @(negedge clk);
         if (!run_busy) begin fin = 1'b1; break; end
      end
      chk(fin, "R6 run bit clears itself", int'(fin), 1);
   endtask

   task automatic measure(input int src, input int L, input int div, output int res);
      bit fin;
      @(negedge clk);
      src_sel = src[0:0]; win_load = L[15:0]; prediv = div[7:0];
      pulse_run();
      chk(run_busy == 1'b1, "R2 run bit set after request", int'(run_busy), 1);
      wait_idle(fin);
      res = int'(count_out);
   endtask

   task automatic t_reset();
      chk(run_busy == 1'b0, "R1 reset run_busy", int'(run_busy), 0);
      chk(count_out == 16'd0, "R1 reset count_out", int'(count_out), 0);
   endtask

   task automatic t_enable_only();
      meter_en = 1'b1;
      repeat (10) @(negedge clk);
      chk(run_busy == 1'b0, "R2 enable alone starts nothing", int'(run_busy), 0);
   endtask

   task automatic t_basic();
      int r;
      measure(0, 511, 0, r);
      near(r, expect_cnt(511, 2.0 * h0, 0), 2, "R3 window count osc0");
   endtask

   task automatic t_source();
      int r;
      measure(1, 511, 0, r);
      near(r, expect_cnt(511, 2.0 * h1, 0), 2, "R4 source select osc1");
   endtask

   task automatic t_prescale();
      int r;
      measure(0, 511, 3, r);
      near(r, expect_cnt(511, 2.0 * h0, 3), 2, "R5 prescaler by 4");
   endtask

   task automatic t_hold();
      int r;
      int later;
      measure(0, 127, 0, r);
      repeat (30) @(negedge clk);
      later = int'(count_out);
      chk(later == r, "R6 count holds while idle", later, r);
   endtask

   task automatic t_saturate();
      int r;
      h0 = 1.0;
      repeat (4) @(negedge clk);
      measure(0, 4095, 0, r);
      chk(r == 65535, "R7 saturation at 0xFFFF", r, 65535);
      h0 = 5.0;
      repeat (4) @(negedge clk);
   endtask

   task automatic t_clear_short();
      int r;
      measure(0, 0, 0, r);
      near(r, expect_cnt(0, 2.0 * h0, 0), 2, "R8 counter cleared at new run");
      chk(r <= 6, "R11 one reference cycle window", r, expect_cnt(0, 2.0 * h0, 0));
      measure(0, 3, 0, r);
      near(r, expect_cnt(3, 2.0 * h0, 0), 2, "R11 four reference cycle window");
   endtask

   task automatic t_disabled();
      int prev;
      prev = int'(count_out);
      meter_en = 1'b0;
      pulse_run();
      repeat (20) @(negedge clk);
      chk(run_busy == 1'b0, "R9 disabled request ignored", int'(run_busy), 0);
      chk(int'(count_out) == prev, "R9 count unchanged when disabled", int'(count_out), prev);
      meter_en = 1'b1;
   endtask

   task automatic t_busy_ignore();
      bit fin;
      int r;
      @(negedge clk);
      src_sel = 1'b0; win_load = 16'd511; prediv = 8'd0;
      pulse_run();
      repeat (100) @(negedge clk);
      src_sel = 1'b1; win_load = 16'd255; prediv = 8'd3;
      pulse_run();
      chk(run_busy == 1'b1, "R10 still busy after second request", int'(run_busy), 1);
      wait_idle(fin);
      r = int'(count_out);
      near(r, expect_cnt(511, 2.0 * h0, 0), 2, "R10 mid-run changes ignored");
      repeat (30) @(negedge clk);
      chk(run_busy == 1'b0, "R10 no second run started", int'(run_busy), 0);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL R6 watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_enable_only();
      t_basic();
      t_source();
      t_prescale();
      t_hold();
      t_saturate();
      t_clear_short();
      t_disabled();
      t_busy_ignore();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule